// File: doc/BRIEF.md
# Burst Address Generator with Return Point

This block produces the address a synchronous memory port uses on each rising clock edge. Three active-low controls pick the source of that address. A repeat control returns the address to a saved return point. An address strobe takes the external address. A count enable moves to the next address. When none of them is asserted, the previous address is used again. The selected address leaves the block combinationally, so the memory array can use it on the same edge. It is also registered as the previous address for the next cycle.

Every strobe load also copies the external address into a return-point register. A later repeat request jumps back to that value. The return-point register has no reset, so its content is undefined until the first strobe load. Because it has no reset, a value that was loaded before a reset is still there afterwards. The block has no chip-select or byte-select inputs. Counting goes on whether or not the memory port is selected.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the previous address is zero. With all three controls high, the address used is 0.
- R2: When `repeatN` is low, the address used is the value in the return-point register as it stood before this edge. The values of `loadN` and `countEnN` make no difference.
- R3: When `repeatN` is high and `loadN` is low, the address used is `extAddr`. The value of `countEnN` makes no difference.
- R4: When `repeatN`, `loadN` and `countEnN` are all high, the address used equals the previous address. `extAddr` is ignored.
- R5: When `repeatN` and `loadN` are high and `countEnN` is low, the address used is the previous address plus one.
- R6: Counting up from the all-ones address gives address zero.
- R7: Every edge with `loadN` low writes `extAddr` into the return-point register, even when `repeatN` is also low. In that case the address used on that edge is still the older return point.
- R8: The address used on an edge becomes the previous address for the next edge, whichever source supplied it.
- R9: Reset does not clear the return-point register. A repeat after reset returns the last address loaded before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the previous-address register |
| extAddr | input | ADDR_W | External address |
| loadN | input | 1 | Active-low address strobe: take extAddr and save it as the return point |
| countEnN | input | 1 | Active-low count enable |
| repeatN | input | 1 | Active-low jump to the return point |
| addrUsed | output | ADDR_W | Address used for the access on the coming edge |

## Verification
A fixed sequence first takes the block through load, count, hold and repeat. It also covers the overlapping cases: a strobe together with count enable, repeat together with count enable, and repeat together with a strobe. These cases show whether the priority is repeat first, then strobe, then count. The repeat-with-strobe vector also shows that the return point is replaced only after the current edge has used the old value. A load just below the all-ones address, followed by counting, covers the wrap to zero. Random control sequences are compared with a priority model. A reset placed between a load and a repeat shows that the return point survives reset while the previous address does not.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  // Source of the address used on the coming edge, highest priority last
  typedef enum logic [1:0] {
    SRC_HOLD   = 2'd0,
    SRC_INCR   = 2'd1,
    SRC_EXT    = 2'd2,
    SRC_REPEAT = 2'd3
  } addrSrc_e;

  // Strobes handed from the control decoder to the datapath
  typedef struct packed {
    addrSrc_e src;
    logic     captureRep;
  } ctrlStrobe_t;

endpackage

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
  import burst_addr_pkg::*;
(
  input  logic        loadN,
  input  logic        countEnN,
  input  logic        repeatN,
  output ctrlStrobe_t strb
);

  // Priority: repeat, then strobe, then count enable, else hold
  always_comb begin
    if (!repeatN) begin
      strb.src = SRC_REPEAT;
    end else if (!loadN) begin
      strb.src = SRC_EXT;
    end else if (!countEnN) begin
      strb.src = SRC_INCR;
    end else begin
      strb.src = SRC_HOLD;
    end
    // The strobe always saves the return point, independent of repeat
    strb.captureRep = !loadN;
  end

endmodule

// File: rtl/burst_addr_dp.sv
module burst_addr_dp
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] addrUsed
);

  localparam logic [ADDR_W-1:0] STEP   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ZERO   = '0;
  localparam logic [ADDR_W-1:0] ALLONE = '1;

  logic [ADDR_W-1:0] prevAddr;
  logic [ADDR_W-1:0] repReg;
  logic [ADDR_W-1:0] incAddr;
  logic [ADDR_W-1:0] addrNext;

  // Modulo-2^ADDR_W increment, so all-ones wraps to zero
  assign incAddr = prevAddr + STEP;

  always_comb begin
    unique case (strb.src)
      SRC_REPEAT: addrNext = repReg;
      SRC_EXT:    addrNext = extAddr;
      SRC_INCR:   addrNext = incAddr;
      default:    addrNext = prevAddr;
    endcase
  end

  assign addrUsed = addrNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevAddr <= ZERO;
    end else begin
      prevAddr <= addrNext;
    end
  end

  // Return point: deliberately without reset
  always_ff @(posedge clk) begin
    if (strb.captureRep) begin
      repReg <= extAddr;
    end
  end

  AST_HOLD_REUSES: assert property (@(posedge clk) disable iff (!rstN)
    (strb.src == SRC_HOLD) |=> prevAddr == $past(prevAddr)); // R4
  AST_INCR_STEPS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.src == SRC_INCR) |=> prevAddr == $past(prevAddr) + STEP); // R5
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.src == SRC_INCR && prevAddr == ALLONE) |=> prevAddr == ZERO); // R6
  AST_CAPTURE_REP: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureRep |=> repReg == $past(extAddr)); // R7
  AST_REPEAT_RETURNS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.src == SRC_REPEAT) |=> prevAddr == $past(repReg)); // R2

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              loadN,
  input  logic              countEnN,
  input  logic              repeatN,
  output logic [ADDR_W-1:0] addrUsed
);

  ctrlStrobe_t strb;

  burst_addr_ctrl u_ctrl (
    .loadN    (loadN),
    .countEnN (countEnN),
    .repeatN  (repeatN),
    .strb     (strb)
  );

  burst_addr_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .extAddr  (extAddr),
    .addrUsed (addrUsed)
  );

  AST_REPEAT_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    !repeatN |-> strb.src == SRC_REPEAT); // R2
  AST_STROBE_USES_EXT: assert property (@(posedge clk) disable iff (!rstN)
    (repeatN && !loadN) |-> addrUsed == extAddr); // R3
  AST_USED_BECOMES_PREV: assert property (@(posedge clk) disable iff (!rstN)
    (repeatN && loadN && countEnN) |=> addrUsed == $past(addrUsed) || !loadN || !repeatN || !countEnN); // R8

endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

  localparam int AW = 18;
  localparam int NV = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] extAddr = '0;
  logic          loadN = 1'b1;
  logic          countEnN = 1'b1;
  logic          repeatN = 1'b1;
  logic [AW-1:0] addrUsed;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .extAddr  (extAddr),
    .loadN    (loadN),
    .countEnN (countEnN),
    .repeatN  (repeatN),
    .addrUsed (addrUsed)
  );

  // {req[3:0], {repeatN,loadN,countEnN}, extAddr, expected}
  localparam logic [42:0] VEC [NV] = '{
    {4'd3, 3'b101, 18'h00100, 18'h00100},
    {4'd5, 3'b110, 18'h3FFFF, 18'h00101},
    {4'd5, 3'b110, 18'h00000, 18'h00102},
    {4'd4, 3'b111, 18'h12345, 18'h00102},
    {4'd3, 3'b100, 18'h2A000, 18'h2A000},
    {4'd5, 3'b110, 18'h00000, 18'h2A001},
    {4'd2, 3'b011, 18'h11111, 18'h2A000},
    {4'd8, 3'b110, 18'h00000, 18'h2A001},
    {4'd2, 3'b010, 18'h00000, 18'h2A000},
    {4'd7, 3'b001, 18'h05555, 18'h2A000},
    {4'd8, 3'b110, 18'h00000, 18'h2A001},
    {4'd7, 3'b011, 18'h00000, 18'h05555},
    {4'd3, 3'b101, 18'h3FFFE, 18'h3FFFE},
    {4'd5, 3'b110, 18'h00000, 18'h3FFFF},
    {4'd6, 3'b110, 18'h00000, 18'h00000},
    {4'd4, 3'b111, 18'h3FFFF, 18'h00000}
  };

  task automatic check(input logic [AW-1:0] exp, input string tag);
    checks++;
    if (addrUsed !== exp) begin
      errors++;
      $display("FAIL %s addrUsed=%h expected=%h", tag, addrUsed, exp);
    end
  endtask

  // Drive at the falling edge, check before the next rising edge
  task automatic step(input logic [2:0] ctl, input logic [AW-1:0] ext,
                      input logic [AW-1:0] exp, input string tag);
    @(negedge clk);
    {repeatN, loadN, countEnN} = ctl;
    extAddr = ext;
    #1;
    check(exp, tag);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    logic [AW-1:0] mPrev;
    logic [AW-1:0] mRep;
    logic [AW-1:0] exp;
    repeat (3) @(negedge clk);
    #1;
    check('0, "R1 during reset");
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check('0, "R1 after release");

    // Table walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][38:36], VEC[i][35:18], VEC[i][17:0],
           $sformatf("R%0d vector %0d", VEC[i][42:39], i));
    end

    // Random sequences against the priority model; first load defines mRep
    step(3'b101, 18'h0ABCD, 18'h0ABCD, "R3 seed load");
    mPrev = 18'h0ABCD;
    mRep  = 18'h0ABCD;
    for (int i = 0; i < 400; i++) begin
      logic [2:0] ctl;
      logic [AW-1:0] ext;
      ctl[2] = ($urandom_range(0, 5) != 0);
      ctl[1] = ($urandom_range(0, 3) != 0);
      ctl[0] = ($urandom_range(0, 2) == 0);
      ext = AW'($urandom);
      if (i % 50 == 7) ext = '1;
      if (!ctl[2])      exp = mRep;
      else if (!ctl[1]) exp = ext;
      else if (!ctl[0]) exp = mPrev + AW'(1);
      else              exp = mPrev;
      step(ctl, ext, exp, "R2/R3/R4/R5/R7/R8 random");
      if (!ctl[1]) mRep = ext;
      mPrev = exp;
    end

    // Reset keeps the return point (R9), clears previous address (R1)
    step(3'b101, 18'h1ABCD, 18'h1ABCD, "R3 load before reset");
    step(3'b110, 18'h00000, 18'h1ABCE, "R5 count before reset");
    @(negedge clk);
    {repeatN, loadN, countEnN} = 3'b111;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
    check('0, "R1 after second reset");
    step(3'b011, 18'h00000, 18'h1ABCD, "R9 return point survives reset");
    step(3'b110, 18'h00000, 18'h1ABCE, "R8 count after repeat");
    step(3'b111, 18'h3FFFF, 18'h1ABCE, "R4 hold ignores ext");

    finishRun();
  end

endmodule